// File: doc/BRIEF.md
# Push-Button Debounce and Long-Press Reset Controller

This block watches a single active-low push button and sorts each genuine press into one of two actions. The raw input is synchronized and glitch-filtered, then a six-state machine debounces it. If the button is released before a selectable hold threshold, the block raises a one-cycle soft-reset/interrupt strobe. If the button is held to that threshold, it drives a fixed-width, active-low hard-reset request.

All timing comes from one free-running clock. Each time constant is an elaboration parameter in microseconds and is scaled by a clock-rate parameter. An input qualifier marks the supply as good. While it is low, the controller stays idle and silent. After it rises, and after every action, presses are ignored for an inhibit window. After a hard reset, the machine waits until the button has been released and is stable. If that wait lasts too long (a stuck or chattering button), a fuse latches and blocks further hard resets until it is cleared.

Top module: `pb_reset_ctrl`

## Requirements
- R1: While `rstN` is low and just after it is released, `softStrobe` is 0, `hardRstN` is 1 and `fuseFlag` is 0.
- R2: A low pulse on `btnN` (0 = pressed) shorter than the glitch time (GLITCH_US cycles-scaled) never starts a press and produces no strobe and no reset.
- R3: A press is accepted only after the filtered input has stayed pressed for the debounce time. A shorter press, or bounce that breaks the window, produces no action. A press broken by bounce counts once.
- R4: A press released after acceptance and before the hold threshold raises `softStrobe` for exactly one cycle, and only once.
- R5: The hold threshold is picked by `longSel`: 0 selects LONG_A_US, 1 selects LONG_B_US, 2 selects LONG_C_US, and 3 selects LONG_B_US (the default bin). A press held past the threshold drives `hardRstN` low.
- R6: `hardRstN` stays low for exactly PULSE_US (scaled) cycles, whether the button is released during the pulse or held long after it.
- R7: Presses that end within the inhibit time after `powerGood` rises, or after the machine returns to idle from any action, produce no action.
- R8: After a hard reset, no further strobe or reset occurs until the button has been released and stable for the debounce time. Release bounce is swallowed.
- R9: If the post-reset release wait lasts FUSE_US (scaled) cycles, `fuseFlag` rises. While it is set, a long press produces no hard reset. A one-cycle `fuseClr` clears it.
- R10: While `powerGood` is low, all outputs are deasserted and the machine returns to idle. The first cycle after it rises shows no strobe and no reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rstN | input | 1 | Asynchronous active-low reset |
| powerGood | input | 1 | Supply-good qualifier, synchronous to `clk` |
| btnN | input | 1 | Raw button, low when pressed, asynchronous |
| longSel | input | 2 | Hold-threshold bin select |
| fuseClr | input | 1 | Clears the stuck-button fuse |
| softStrobe | output | 1 | One-cycle short-press strobe |
| hardRstN | output | 1 | Active-low fixed-width hard-reset request |
| fuseFlag | output | 1 | Stuck-button fuse latched |

## Verification
In the cycle counts below, edge 1 is the first clock edge that samples a new button level, and G and D are the glitch and debounce times in cycles. The filtered level changes after edge G+2. A short-press strobe is therefore high during the cycle that follows edge G+2 of the release. A long press drives `hardRstN` low after edge G+D+L+4, where L is the hold threshold, and the pulse lasts exactly the pulse time. The bench steps a behavioural model on the same edges as the design. It compares all three outputs one nanosecond after every falling edge, where every register has settled and every input has already been applied. Scenario checks count strobes, reset pulses and pulse widths only after waits longer than the release, debounce and inhibit windows, so no result depends on the exact cycle at which the wait ends.

// File: rtl/pb_pkg.sv
package pb_pkg;

  localparam int SYNC_STAGES = 2;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_DEBOUNCE = 3'd1,
    ST_PRESSED  = 3'd2,
    ST_LONG     = 3'd3,
    ST_PULSE    = 3'd4,
    ST_RELWAIT  = 3'd5
  } pbState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clrTmr;
    logic inRelWait;
    logic fuseRst;
  } pbCtl_t;

  // status from datapath to control
  typedef struct packed {
    logic pressed;
    logic inhDone;
    logic debDone;
    logic longDone;
    logic pulseDone;
    logic fuse;
  } pbSts_t;

  function automatic longint unsigned lmax(longint unsigned a, longint unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pb_datapath.sv
module pb_datapath
  import pb_pkg::*;
#(
  parameter int TW = 8,
  parameter longint unsigned GLITCH_CYC = 3,
  parameter longint unsigned DEB_CYC    = 20,
  parameter longint unsigned LONGA_CYC  = 60,
  parameter longint unsigned LONGB_CYC  = 100,
  parameter longint unsigned LONGC_CYC  = 140,
  parameter longint unsigned PULSE_CYC  = 30,
  parameter longint unsigned INH_CYC    = 50,
  parameter longint unsigned FUSE_CYC   = 200
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       btnN,
  input  logic [1:0] longSel,
  input  pbCtl_t     ctl,
  output pbSts_t     sts
);

  localparam int GW = (GLITCH_CYC > 1) ? $clog2(GLITCH_CYC) : 1;
  localparam int FW = (FUSE_CYC > 1) ? $clog2(FUSE_CYC) : 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   rawPressed;
  logic                   filtPressed;
  logic [GW-1:0]          glitchCnt;
  logic [TW-1:0]          tmr;
  logic [FW-1:0]          fuseCnt;
  logic                   fuseQ;
  logic                   longHit;

  // input synchronizer, resets to "released"
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], btnN};
  end

  assign rawPressed = ~syncQ[SYNC_STAGES-1];

  // glitch filter: level must differ for GLITCH_CYC straight cycles
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      filtPressed <= 1'b0;
      glitchCnt   <= '0;
    end else if (rawPressed != filtPressed) begin
      if (glitchCnt == GW'(GLITCH_CYC - 1)) begin
        filtPressed <= rawPressed;
        glitchCnt   <= '0;
      end else begin
        glitchCnt <= glitchCnt + 1'b1;
      end
    end else begin
      glitchCnt <= '0;
    end
  end

  // shared saturating phase timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               tmr <= '0;
    else if (ctl.clrTmr)     tmr <= '0;
    else if (tmr != '1)      tmr <= tmr + 1'b1;
  end

  // release-wait watchdog and fuse
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fuseCnt <= '0;
      fuseQ   <= 1'b0;
    end else begin
      if (!ctl.inRelWait)                        fuseCnt <= '0;
      else if (fuseCnt != FW'(FUSE_CYC - 1))     fuseCnt <= fuseCnt + 1'b1;
      if (ctl.fuseRst)                           fuseQ <= 1'b0;
      else if (ctl.inRelWait && fuseCnt == FW'(FUSE_CYC - 1)) fuseQ <= 1'b1;
    end
  end

  always_comb begin
    unique case (longSel)
      2'd0:    longHit = (tmr == TW'(LONGA_CYC - 1));
      2'd2:    longHit = (tmr == TW'(LONGC_CYC - 1));
      default: longHit = (tmr == TW'(LONGB_CYC - 1));
    endcase
  end

  assign sts.pressed   = filtPressed;
  assign sts.inhDone   = (tmr >= TW'(INH_CYC - 1));
  assign sts.debDone   = (tmr == TW'(DEB_CYC - 1));
  assign sts.longDone  = longHit;
  assign sts.pulseDone = (tmr == TW'(PULSE_CYC - 1));
  assign sts.fuse      = fuseQ;

endmodule

// File: rtl/pb_control.sv
module pb_control
  import pb_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   powerGood,
  input  logic   fuseClr,
  input  pbSts_t sts,
  output pbCtl_t ctl,
  output logic   softStrobe,
  output logic   hardRstN,
  output logic   fuseFlag
);

  pbState_e st, stNext;
  logic     clrTmr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) st <= ST_IDLE;
    else       st <= stNext;
  end

  always_comb begin
    stNext = st;
    clrTmr = 1'b0;
    if (!powerGood) begin
      stNext = ST_IDLE;
      clrTmr = 1'b1;
    end else begin
      unique case (st)
        ST_IDLE: if (sts.inhDone && sts.pressed) begin
          stNext = ST_DEBOUNCE;
          clrTmr = 1'b1;
        end
        ST_DEBOUNCE: if (!sts.pressed) begin
          stNext = ST_IDLE;
          clrTmr = 1'b1;
        end else if (sts.debDone) begin
          stNext = ST_PRESSED;
          clrTmr = 1'b1;
        end
        ST_PRESSED: if (!sts.pressed) begin
          stNext = ST_IDLE;
          clrTmr = 1'b1;
        end else if (sts.longDone) begin
          stNext = ST_LONG;
          clrTmr = 1'b1;
        end
        ST_LONG: begin
          stNext = sts.fuse ? ST_RELWAIT : ST_PULSE;
          clrTmr = 1'b1;
        end
        ST_PULSE: if (sts.pulseDone) begin
          stNext = ST_RELWAIT;
          clrTmr = 1'b1;
        end
        ST_RELWAIT: if (sts.pressed) begin
          clrTmr = 1'b1;
        end else if (sts.debDone) begin
          stNext = ST_IDLE;
          clrTmr = 1'b1;
        end
        default: begin
          stNext = ST_IDLE;
          clrTmr = 1'b1;
        end
      endcase
    end
  end

  assign ctl.clrTmr    = clrTmr;
  assign ctl.inRelWait = (st == ST_RELWAIT);
  assign ctl.fuseRst   = ~powerGood | fuseClr;

  assign softStrobe = powerGood && (st == ST_PRESSED) && !sts.pressed;
  assign hardRstN   = !(powerGood && (st == ST_PULSE));
  assign fuseFlag   = powerGood && sts.fuse;

endmodule

// File: rtl/pb_reset_ctrl.sv
module pb_reset_ctrl
  import pb_pkg::*;
#(
  parameter longint unsigned CLK_MHZ   = 250,
  parameter longint unsigned GLITCH_US = 5,
  parameter longint unsigned DEB_US    = 25_000,
  parameter longint unsigned LONG_A_US = 2_000_000,
  parameter longint unsigned LONG_B_US = 5_000_000,
  parameter longint unsigned LONG_C_US = 8_000_000,
  parameter longint unsigned PULSE_US  = 100_000,
  parameter longint unsigned INH_US    = 200_000,
  parameter longint unsigned FUSE_US   = 10_000_000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       powerGood,
  input  logic       btnN,
  input  logic [1:0] longSel,
  input  logic       fuseClr,
  output logic       softStrobe,
  output logic       hardRstN,
  output logic       fuseFlag
);

  localparam longint unsigned GLITCH_CYC = CLK_MHZ * GLITCH_US;
  localparam longint unsigned DEB_CYC    = CLK_MHZ * DEB_US;
  localparam longint unsigned LONGA_CYC  = CLK_MHZ * LONG_A_US;
  localparam longint unsigned LONGB_CYC  = CLK_MHZ * LONG_B_US;
  localparam longint unsigned LONGC_CYC  = CLK_MHZ * LONG_C_US;
  localparam longint unsigned PULSE_CYC  = CLK_MHZ * PULSE_US;
  localparam longint unsigned INH_CYC    = CLK_MHZ * INH_US;
  localparam longint unsigned FUSE_CYC   = CLK_MHZ * FUSE_US;
  localparam longint unsigned MAX_CYC    =
    lmax(lmax(lmax(DEB_CYC, LONGA_CYC), lmax(LONGB_CYC, LONGC_CYC)), lmax(PULSE_CYC, INH_CYC));
  localparam int TW = $clog2(MAX_CYC + 1);

  pbCtl_t ctl;
  pbSts_t sts;

  pb_datapath #(
    .TW(TW), .GLITCH_CYC(GLITCH_CYC), .DEB_CYC(DEB_CYC),
    .LONGA_CYC(LONGA_CYC), .LONGB_CYC(LONGB_CYC), .LONGC_CYC(LONGC_CYC),
    .PULSE_CYC(PULSE_CYC), .INH_CYC(INH_CYC), .FUSE_CYC(FUSE_CYC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .btnN(btnN), .longSel(longSel), .ctl(ctl), .sts(sts)
  );

  pb_control u_ctl (
    .clk(clk), .rstN(rstN), .powerGood(powerGood), .fuseClr(fuseClr), .sts(sts),
    .ctl(ctl), .softStrobe(softStrobe), .hardRstN(hardRstN), .fuseFlag(fuseFlag)
  );

endmodule

// File: rtl/pb_reset_ctrl_chk.sv
module pb_reset_ctrl_chk #(
  parameter longint unsigned PULSE_CYC = 30
) (
  input logic clk,
  input logic rstN,
  input logic powerGood,
  input logic fuseClr,
  input logic softStrobe,
  input logic hardRstN,
  input logic fuseFlag
);

  logic [31:0] lowRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         lowRun <= '0;
    else if (hardRstN) lowRun <= '0;
    else               lowRun <= lowRun + 1'b1;
  end

  // R6: an uninterrupted pulse ends after exactly the pulse width
  a_r6_pulse_width: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(hardRstN) && powerGood && $past(powerGood)) |-> (lowRun == 32'(PULSE_CYC)));

  // R4: the short-press strobe is a single cycle
  a_r4_single_cycle: assert property (@(posedge clk) disable iff (!rstN)
    softStrobe |=> !softStrobe);

  // R4: soft and hard actions never coincide
  a_r4_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(softStrobe && !hardRstN));

  // R9: a latched fuse blocks the start of a hard reset
  a_r9_fuse_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (fuseFlag && !fuseClr && hardRstN) |=> hardRstN);

  // R10: machine is idle on the first cycle after power-good returns
  a_r10_idle_after_pg: assert property (@(posedge clk) disable iff (!rstN)
    ($past(!powerGood) && powerGood) |-> (hardRstN && !softStrobe && !fuseFlag));

endmodule

bind pb_reset_ctrl pb_reset_ctrl_chk #(.PULSE_CYC(PULSE_CYC)) u_chk (
  .clk(clk), .rstN(rstN), .powerGood(powerGood), .fuseClr(fuseClr),
  .softStrobe(softStrobe), .hardRstN(hardRstN), .fuseFlag(fuseFlag)
);

// File: tb/pb_reset_ctrl_tb.sv
`timescale 1ns/1ps
module pb_reset_ctrl_tb;

  localparam int GL = 3, DB = 20, LA = 60, LB = 100, LC = 140;
  localparam int PU = 30, IN = 50, FU = 200;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rstN = 1'b0, powerGood = 1'b0, btnN = 1'b1, fuseClr = 1'b0;
  logic [1:0] longSel = 2'd0;
  logic       softStrobe, hardRstN, fuseFlag;

  pb_reset_ctrl #(
    .CLK_MHZ(1), .GLITCH_US(GL), .DEB_US(DB), .LONG_A_US(LA), .LONG_B_US(LB),
    .LONG_C_US(LC), .PULSE_US(PU), .INH_US(IN), .FUSE_US(FU)
  ) u_dut (
    .clk(clk), .rstN(rstN), .powerGood(powerGood), .btnN(btnN), .longSel(longSel),
    .fuseClr(fuseClr), .softStrobe(softStrobe), .hardRstN(hardRstN), .fuseFlag(fuseFlag)
  );

  int total = 0, bad = 0, shown = 0;
  int softCnt = 0, hardCnt = 0, curWidth = 0, lastWidth = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      if (shown < 30) begin
        shown++;
        $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
      end
    end
  endtask

  // behavioural reference: phase 0 idle,1 debounce,2 held,3 decide,4 pulse,5 release wait
  int mS1 = 1, mS2 = 1, mFilt = 0, mAge = 0, mPh = 0, mT = 0, mWait = 0, mFuse = 0;

  always @(posedge clk) begin
    int raw, nFilt, nAge, nPh, nT, nWait, nFuse, lim;
    bit clr;
    if (!rstN) begin
      mS1 = 1; mS2 = 1; mFilt = 0; mAge = 0; mPh = 0; mT = 0; mWait = 0; mFuse = 0;
    end else begin
      raw = (mS2 == 0) ? 1 : 0;
      nFilt = mFilt; nAge = 0;
      if (raw != mFilt) begin
        if (mAge == GL - 1) nFilt = raw;
        else nAge = mAge + 1;
      end
      lim = (longSel == 2'd0) ? LA : (longSel == 2'd2) ? LC : LB;
      nPh = mPh; clr = 0;
      if (!powerGood) begin nPh = 0; clr = 1; end
      else begin
        case (mPh)
          0: if (mT >= IN - 1 && mFilt == 1) begin nPh = 1; clr = 1; end
          1: if (mFilt == 0) begin nPh = 0; clr = 1; end
             else if (mT == DB - 1) begin nPh = 2; clr = 1; end
          2: if (mFilt == 0) begin nPh = 0; clr = 1; end
             else if (mT == lim - 1) begin nPh = 3; clr = 1; end
          3: begin nPh = (mFuse != 0) ? 5 : 4; clr = 1; end
          4: if (mT == PU - 1) begin nPh = 5; clr = 1; end
          default: if (mFilt == 1) clr = 1;
                   else if (mT == DB - 1) begin nPh = 0; clr = 1; end
        endcase
      end
      nT = clr ? 0 : mT + 1;
      nWait = (mPh != 5) ? 0 : ((mWait < FU - 1) ? mWait + 1 : mWait);
      if (!powerGood || fuseClr) nFuse = 0;
      else if (mPh == 5 && mWait == FU - 1) nFuse = 1;
      else nFuse = mFuse;
      mS2 = mS1; mS1 = btnN;
      mFilt = nFilt; mAge = nAge; mPh = nPh; mT = nT; mWait = nWait; mFuse = nFuse;
    end
  end

  // per-cycle comparison and event counting
  always @(negedge clk) begin
    #1;
    if (rstN && !finished) begin
      check(softStrobe == (powerGood && mPh == 2 && mFilt == 0), "R4 softStrobe cycle",
            softStrobe, (powerGood && mPh == 2 && mFilt == 0));
      check(hardRstN == !(powerGood && mPh == 4), "R5 hardRstN cycle",
            hardRstN, !(powerGood && mPh == 4));
      check(fuseFlag == (powerGood && mFuse != 0), "R9 fuseFlag cycle",
            fuseFlag, (powerGood && mFuse != 0));
      if (softStrobe) softCnt++;
      if (!hardRstN) begin
        if (curWidth == 0) hardCnt++;
        curWidth++;
      end else if (curWidth != 0) begin
        lastWidth = curWidth;
        curWidth = 0;
      end
    end
  end

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic press(input int n);
    @(negedge clk); btnN = 1'b0;
    waitCyc(n);
    btnN = 1'b1;
  endtask

  task automatic summary();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    int s0, h0;
    powerGood = 1'b1;
    waitCyc(5);
    #1;
    check(softStrobe == 0 && hardRstN == 1 && fuseFlag == 0, "R1 outputs in reset",
          {softStrobe, hardRstN, fuseFlag}, 3'b010);
    @(negedge clk); rstN = 1'b1;
    #1;
    check(softStrobe == 0 && hardRstN == 1 && fuseFlag == 0, "R1 outputs after reset",
          {softStrobe, hardRstN, fuseFlag}, 3'b010);
    waitCyc(60);

    // R2: short glitches
    for (int i = 0; i < 4; i++) begin
      btnN = 1'b0; waitCyc(2); btnN = 1'b1; waitCyc(10);
    end
    waitCyc(40);
    check(softCnt == 0 && hardCnt == 0, "R2 glitches ignored", softCnt + hardCnt, 0);

    // R4: clean short press
    press(40); waitCyc(80);
    check(softCnt == 1, "R4 one strobe per short press", softCnt, 1);

    // R3: press shorter than debounce
    press(15); waitCyc(80);
    check(softCnt == 1, "R3 sub-debounce press ignored", softCnt, 1);

    // R3: bounce then steady hold counts once
    for (int i = 0; i < 5; i++) begin
      btnN = 1'b0; waitCyc(4); btnN = 1'b1; waitCyc(4);
    end
    press(40); waitCyc(80);
    check(softCnt == 2, "R3 bouncy press counted once", softCnt, 2);

    // R7: second press inside inhibit window after an action
    press(30); waitCyc(8); press(30); waitCyc(80);
    check(softCnt == 3, "R7 press during inhibit ignored", softCnt, 3);

    // R5/R6/R8: long press with release bounce
    longSel = 2'd0;
    btnN = 1'b0; waitCyc(150);
    for (int i = 0; i < 4; i++) begin
      btnN = 1'b1; waitCyc(3); btnN = 1'b0; waitCyc(3);
    end
    btnN = 1'b1; waitCyc(100);
    check(hardCnt == 1, "R5 long press gives hard reset", hardCnt, 1);
    check(lastWidth == PU, "R6 pulse width held", lastWidth, PU);
    check(softCnt == 3, "R8 release bounce swallowed", softCnt, 3);

    // R6: release during the pulse
    press(90); waitCyc(100);
    check(hardCnt == 2 && lastWidth == PU, "R6 width independent of release",
          lastWidth, PU);

    // R5: bins
    longSel = 2'd1; press(110); waitCyc(100);
    check(softCnt == 4 && hardCnt == 2, "R5 bin B below threshold", hardCnt, 2);
    press(180); waitCyc(100);
    check(hardCnt == 3, "R5 bin B reached", hardCnt, 3);
    longSel = 2'd2; press(150); waitCyc(100);
    check(softCnt == 5 && hardCnt == 3, "R5 bin C below threshold", hardCnt, 3);
    press(220); waitCyc(100);
    check(hardCnt == 4, "R5 bin C reached", hardCnt, 4);
    longSel = 2'd3; press(180); waitCyc(100);
    check(hardCnt == 5, "R5 select 3 uses bin B", hardCnt, 5);

    // R9: stuck button trips fuse
    longSel = 2'd0; press(400); waitCyc(100);
    #1;
    check(hardCnt == 6, "R9 reset before fuse", hardCnt, 6);
    check(fuseFlag == 1, "R9 fuse latched", fuseFlag, 1);
    press(150); waitCyc(100);
    check(hardCnt == 6, "R9 fuse blocks hard reset", hardCnt, 6);
    @(negedge clk); fuseClr = 1'b1; @(negedge clk); fuseClr = 1'b0;
    waitCyc(2); #1;
    check(fuseFlag == 0, "R9 fuse cleared", fuseFlag, 0);
    press(150); waitCyc(100);
    check(hardCnt == 7, "R9 resets resume after clear", hardCnt, 7);

    // R10: power-good drop during a pulse
    s0 = softCnt; h0 = hardCnt;
    @(negedge clk); btnN = 1'b0;
    for (int i = 0; i < 300 && hardRstN; i++) @(negedge clk);
    waitCyc(5);
    powerGood = 1'b0; #1;
    check(hardRstN == 1, "R10 pulse released on power loss", hardRstN, 1);
    waitCyc(3); btnN = 1'b1; waitCyc(5);
    press(40); waitCyc(10);
    check(softCnt == s0 && hardCnt == h0 + 1, "R10 silent while power low", softCnt, s0);

    // R7: inhibit after power-good rises
    @(negedge clk); powerGood = 1'b1;
    waitCyc(10); press(30); waitCyc(80);
    check(softCnt == s0, "R7 inhibit after power-good", softCnt, s0);
    press(40); waitCyc(80);
    check(softCnt == s0 + 1, "R7 accepted after inhibit", softCnt, s0 + 1);

    summary();
  end

endmodule